// File: doc/BRIEF.md
# Counter Bit-Toggle Event Stream Generator

This block watches two free-running 64-bit counts and emits a one-cycle interrupt pulse each time a chosen bit of either count flips in a chosen direction. It holds two copies of the same detector. The kernel stream watches the virtual count. The hypervisor stream watches the physical count. Each stream has its own six-bit control word. The word carries an enable bit, an edge-direction bit and a four-bit select field. The select field picks one of the low sixteen counter bits.

The counts are qualified by a tick strobe, which marks the cycles on which the counts have just advanced by one. On such a cycle each detector compares the selected bit of the current count with the same bit of that count minus one. The "minus one" value is derived inside the block, so no earlier sample is stored. A qualifying flip raises the IRQ pulse on the following cycle. A two-bit source field says which stream or streams caused it. While the processor's IRQ mask bit is set, any flip that happens is dropped and not held for later. The count generators and exception entry sit outside this block.

The counts and controls are plain level inputs that the block samples on every clock, so they have no valid/ready handshake. The outputs are a plain pulse and its source field. The block never applies back-pressure, and a pulse that no one observes is lost.

Top module: `cnt_evstream`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `irq_o` is 0 and `irq_src_o` is 2'b00.
- R2: Bit 0 of a control word is the enable bit. While it is 0, that stream never sets its source bit, whatever the count does.
- R3: Bit 1 of a control word is the edge bit. When it is 0 (rising), the stream fires on a tick where bit N is 0 in count-1 and 1 in the count. That is true exactly when the count modulo 2^(N+1) equals 2^N.
- R4: When the edge bit is 1 (falling), the stream fires on a tick where bit N is 1 in count-1 and 0 in the count. That is true exactly when the count modulo 2^(N+1) equals 0.
- R5: Bits 5:2 of a control word give N, the watched bit, which can be any value from 0 to 15. Count bits above N+1 have no effect.
- R6: The kernel stream (control `kctl_i`) evaluates only `vcnt_i`, and the hypervisor stream (control `hctl_i`) evaluates only `pcnt_i`.
- R7: A flip on a tick where `irq_mask_i` is 1 produces no pulse. The flip is not remembered, so no pulse follows once the mask clears.
- R8: A detected flip makes `irq_o` 1 on exactly one cycle: the cycle after the tick was sampled. On cycles where `tick_i` was 0, `irq_o` is 0.
- R9: `irq_src_o[0]` marks the kernel stream and `irq_src_o[1]` marks the hypervisor stream. Flips from both streams on the same tick give one pulse with `irq_src_o` = 2'b11. `irq_src_o` is 2'b00 whenever `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | The counts advanced by one this cycle |
| vcnt_i | input | 64 | Virtual count, watched by the kernel stream |
| pcnt_i | input | 64 | Physical count, watched by the hypervisor stream |
| kctl_i | input | 6 | Kernel stream control: [0] enable, [1] edge, [5:2] bit select |
| hctl_i | input | 6 | Hypervisor stream control, with the same layout |
| irq_mask_i | input | 1 | Processor IRQ mask; 1 suppresses events |
| irq_o | output | 1 | One-cycle event interrupt pulse |
| irq_src_o | output | 2 | Stream(s) that caused the pulse: [0] kernel, [1] hypervisor |

## Verification
The bench sweeps every select value in both edge directions. It uses counts on either side of each 2^N and 2^(N+1) boundary, with unrelated high bits set. A detector that compared the wrong bit, or that tested the level instead of the flip, would then fire one count early or late, or on every count. Separate scenarios give the two streams different counts. These catch a stream reading the other stream's count, and a merge that loses one source when both fire together. Further scenarios test a masked flip followed by an unmasked idle cycle, and a flipping count held across a tick-free cycle. A design that latched masked events, stretched the pulse, or evaluated without a tick would raise a pulse in one of those cycles.

// File: rtl/cnt_evstream_pkg.sv
package cnt_evstream_pkg;
  // Control word field positions (the select field is SEL_W wide).
  localparam int unsigned CTL_EN_POS  = 0;
  localparam int unsigned CTL_DIR_POS = 1;
  localparam int unsigned CTL_SEL_LSB = 2;

  // Stream indices, also the bit positions in the source field.
  localparam int unsigned NUM_STREAMS = 2;
  localparam int unsigned STR_KERN    = 0;
  localparam int unsigned STR_HYP     = 1;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_dir_e;
endpackage

// File: rtl/cnt_evstream_tap.sv
// One detector: compares the selected bit of a count and of count-1.
module cnt_evstream_tap
  import cnt_evstream_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned CTL_W = SEL_W + 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic             hit_o
);
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] bit_mask;
  logic [CNT_W-1:0] prev_cnt;
  logic             cur_bit;
  logic             prev_bit;
  logic             enable;
  edge_dir_e        dir;

  always_comb begin
    sel      = ctl_i[CTL_SEL_LSB +: SEL_W];
    enable   = ctl_i[CTL_EN_POS];
    dir      = edge_dir_e'(ctl_i[CTL_DIR_POS]);
    bit_mask = CNT_W'(1) << sel;
    prev_cnt = cnt_i - CNT_W'(1);
    cur_bit  = |(cnt_i & bit_mask);
    prev_bit = |(prev_cnt & bit_mask);
    unique case (dir)
      EDGE_RISE: hit_o = enable & ~prev_bit &  cur_bit;
      EDGE_FALL: hit_o = enable &  prev_bit & ~cur_bit;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cnt_evstream_merge.sv
// Qualifies raw hits with tick and mask, then registers one pulse.
module cnt_evstream_merge #(
  parameter int unsigned NSTR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            irq_mask_i,
  input  logic [NSTR-1:0] hit_i,
  output logic            irq_o,
  output logic [NSTR-1:0] irq_src_o
);
  logic            accept;
  logic [NSTR-1:0] src_d;

  always_comb begin
    accept = tick_i & ~irq_mask_i;
    src_d  = accept ? hit_i : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      irq_src_o <= '0;
    end else begin
      irq_o     <= |src_d;
      irq_src_o <= src_d;
    end
  end
endmodule

// File: rtl/cnt_evstream.sv
module cnt_evstream
  import cnt_evstream_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned CTL_W = SEL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] vcnt_i,
  input  logic [CNT_W-1:0] pcnt_i,
  input  logic [CTL_W-1:0] kctl_i,
  input  logic [CTL_W-1:0] hctl_i,
  input  logic             irq_mask_i,
  output logic             irq_o,
  output logic [NUM_STREAMS-1:0] irq_src_o
);
  logic [CNT_W-1:0] cnt_arr [NUM_STREAMS];
  logic [CTL_W-1:0] ctl_arr [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] hit;

  always_comb begin
    cnt_arr[STR_KERN] = vcnt_i;
    cnt_arr[STR_HYP]  = pcnt_i;
    ctl_arr[STR_KERN] = kctl_i;
    ctl_arr[STR_HYP]  = hctl_i;
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_tap
    cnt_evstream_tap #(
      .CNT_W(CNT_W),
      .SEL_W(SEL_W)
    ) u_tap (
      .cnt_i(cnt_arr[s]),
      .ctl_i(ctl_arr[s]),
      .hit_o(hit[s])
    );
  end

  cnt_evstream_merge #(
    .NSTR(NUM_STREAMS)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .irq_mask_i(irq_mask_i),
    .hit_i     (hit),
    .irq_o     (irq_o),
    .irq_src_o (irq_src_o)
  );
endmodule

// File: rtl/cnt_evstream_chk.sv
module cnt_evstream_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned CTL_W = SEL_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [CTL_W-1:0] kctl_i,
  input logic [CTL_W-1:0] hctl_i,
  input logic             irq_mask_i,
  input logic             irq_o,
  input logic [1:0]       irq_src_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq_o && irq_src_o == 2'b00));

  a_r2_kern_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!kctl_i[0]) |-> !irq_src_o[0]);

  a_r2_hyp_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hctl_i[0]) |-> !irq_src_o[1]);

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_mask_i) |-> !irq_o);

  a_r8_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i));

  a_r9_src_matches_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == (irq_src_o != 2'b00)));
endmodule

bind cnt_evstream cnt_evstream_chk #(
  .CNT_W(CNT_W),
  .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .kctl_i    (kctl_i),
  .hctl_i    (hctl_i),
  .irq_mask_i(irq_mask_i),
  .irq_o     (irq_o),
  .irq_src_o (irq_src_o)
);

// File: tb/tb_cnt_evstream.sv
`timescale 1ns/1ps
module tb_cnt_evstream;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [63:0] vcnt_i = '0;
  logic [63:0] pcnt_i = '0;
  logic [5:0]  kctl_i = '0;
  logic [5:0]  hctl_i = '0;
  logic        irq_mask_i = 1'b0;
  logic        irq_o;
  logic [1:0]  irq_src_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cnt_evstream dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .vcnt_i(vcnt_i), .pcnt_i(pcnt_i),
    .kctl_i(kctl_i), .hctl_i(hctl_i), .irq_mask_i(irq_mask_i),
    .irq_o(irq_o), .irq_src_o(irq_src_o)
  );

  function automatic logic [5:0] mk_ctl(input bit en, input bit fall, input int n);
    return {4'(n), fall, en};
  endfunction

  // Reference from the requirements: rising fires when c mod 2^(N+1) == 2^N,
  // falling fires when c mod 2^(N+1) == 0.
  function automatic bit ref_hit(input logic [5:0] ctl, input logic [63:0] c);
    int n;
    logic [63:0] m;
    if (!ctl[0]) return 1'b0;
    n = int'(ctl[5:2]);
    m = c & ((64'd2 << n) - 64'd1);
    return ctl[1] ? (m == 64'd0) : (m == (64'd1 << n));
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq/src actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one cycle, then check the registered result after the edge.
  task automatic step(input string req, input bit tk, input logic [63:0] v, input logic [63:0] p);
    logic [1:0] es;
    @(negedge clk);
    tick_i = tk; vcnt_i = v; pcnt_i = p;
    es[0] = tk && !irq_mask_i && ref_hit(kctl_i, v);
    es[1] = tk && !irq_mask_i && ref_hit(hctl_i, p);
    @(posedge clk); #1;
    check(req, {irq_o, irq_src_o}, {|es, es});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    kctl_i = mk_ctl(1, 0, 0); hctl_i = mk_ctl(1, 0, 0);
    @(negedge clk); tick_i = 1'b1; vcnt_i = 64'd1; pcnt_i = 64'd1;
    @(posedge clk); #1;
    check("R1", {irq_o, irq_src_o}, 3'b000);
    @(negedge clk); rst_n = 1'b1; tick_i = 1'b0;
    @(posedge clk); #1;
    check("R1", {irq_o, irq_src_o}, 3'b000);
  endtask

  task automatic t_disabled;
    kctl_i = mk_ctl(0, 0, 0); hctl_i = mk_ctl(0, 1, 3);
    for (int c = 0; c < 40; c++) step("R2", 1'b1, 64'(c), 64'(c));
  endtask

  task automatic t_rise;
    kctl_i = mk_ctl(1, 0, 3); hctl_i = mk_ctl(0, 0, 0);
    for (int c = 1; c < 40; c++) step("R3", 1'b1, 64'(c), 64'd0);
    step("R3", 1'b1, 64'd8, 64'd0);
    check("R3 fires at 8", {irq_o, irq_src_o}, 3'b101);
  endtask

  task automatic t_fall;
    kctl_i = mk_ctl(1, 1, 2); hctl_i = mk_ctl(0, 0, 0);
    for (int c = 1; c < 40; c++) step("R4", 1'b1, 64'(c), 64'd0);
    step("R4", 1'b1, 64'd16, 64'd0);
    check("R4 fires at 16", {irq_o, irq_src_o}, 3'b101);
  endtask

  task automatic t_select;
    logic [63:0] hi;
    logic [63:0] b;
    hi = 64'hA5C3_0000_0000_0000;
    hctl_i = mk_ctl(0, 0, 0);
    for (int n = 0; n < 16; n++) begin
      for (int d = 0; d < 2; d++) begin
        kctl_i = mk_ctl(1, d[0], n);
        b = 64'd1 << n;
        step("R5", 1'b1, hi | b, 64'd0);
        step("R5", 1'b1, hi | (b << 1), 64'd0);
        step("R5", 1'b1, hi | (b + 64'd1), 64'd0);
        step("R5", 1'b1, hi | ((b << 1) + b), 64'd0);
        if (n > 0) step("R5", 1'b1, hi | (b - 64'd1), 64'd0);
      end
    end
  endtask

  task automatic t_source;
    kctl_i = mk_ctl(1, 0, 1); hctl_i = mk_ctl(1, 0, 4);
    step("R6", 1'b1, 64'd2, 64'd3);
    check("R6 kernel only", {irq_o, irq_src_o}, 3'b101);
    step("R6", 1'b1, 64'd3, 64'd16);
    check("R6 hyp only", {irq_o, irq_src_o}, 3'b110);
    step("R6", 1'b1, 64'd16, 64'd2);
    check("R6 swapped counts", {irq_o, irq_src_o}, 3'b000);
  endtask

  task automatic t_mask;
    kctl_i = mk_ctl(1, 0, 0); hctl_i = mk_ctl(1, 1, 0);
    irq_mask_i = 1'b1;
    step("R7", 1'b1, 64'd1, 64'd2);
    check("R7 masked", {irq_o, irq_src_o}, 3'b000);
    irq_mask_i = 1'b0;
    step("R7", 1'b0, 64'd1, 64'd2);
    check("R7 not pended", {irq_o, irq_src_o}, 3'b000);
    step("R7", 1'b1, 64'd3, 64'd2);
    check("R7 unmasked", {irq_o, irq_src_o}, 3'b111);
  endtask

  task automatic t_tick;
    kctl_i = mk_ctl(1, 0, 2); hctl_i = mk_ctl(0, 0, 0);
    step("R8", 1'b0, 64'd4, 64'd0);
    check("R8 no tick", {irq_o, irq_src_o}, 3'b000);
    step("R8", 1'b1, 64'd4, 64'd0);
    check("R8 pulse", {irq_o, irq_src_o}, 3'b101);
    step("R8", 1'b0, 64'd4, 64'd0);
    check("R8 one cycle", {irq_o, irq_src_o}, 3'b000);
  endtask

  task automatic t_merge;
    kctl_i = mk_ctl(1, 1, 5); hctl_i = mk_ctl(1, 0, 0);
    step("R9", 1'b1, 64'h40, 64'h7);
    check("R9 merged", {irq_o, irq_src_o}, 3'b111);
    step("R9", 1'b1, 64'h41, 64'h8);
    check("R9 idle", {irq_o, irq_src_o}, 3'b000);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_disabled();
    t_rise();
    t_fall();
    t_select();
    t_source();
    t_mask();
    t_tick();
    t_merge();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule